// File: doc/BRIEF.md
# Vector Compress Unit

This block gathers the elements of a source vector whose selection bit is set and writes them, in rising index order, into the lowest positions of the result. The selection vector chooses which elements are taken. It is not an execution mask, so every element position of the result is written either by the packing or by the tail rule.

Elements are moved one at a time. A start pulse loads the source vector, the selection bits, the active length `vl`, the previous destination contents and the tail policy. After that the unit reads one source element per clock and advances a write pointer each time it keeps an element. The tail does not begin at `vl`. It begins at the number of kept elements, so it is often longer than an ordinary tail. When the walk finishes, the packed result and the kept-element count are on the outputs and `done` pulses for one cycle. The result stays on the outputs until the next accepted start.

Top module: `vcomp_unit`

## Requirements
- R1: Element i occupies bits [i*ELEM_W +: ELEM_W] of every vector port. The kept elements are the source elements whose `sel_mask` bit is 1 and whose index is below `vl`. They appear at result positions 0, 1, 2, … in the same relative order they had in the source.
- R2: A `sel_mask` bit at an index equal to or above `vl` is ignored. The kept count is therefore never larger than `vl`.
- R3: When `done` is high, `sel_count` equals the number of kept elements.
- R4: With `tail_fill` = 0, every result position at or above the kept count holds the `old_dest` element of that position. This holds even for positions below `vl`.
- R5: With `tail_fill` = 1, every result position at or above the kept count is all ones.
- R6: Call the clock edge that accepts `start` edge 0. `done` is high for exactly one cycle, the cycle that follows edge `vl`. When `vl` is 0, that is the cycle right after edge 0.
- R7: A `vl` above NUM_ELEM is treated as NUM_ELEM, both for selection and for timing.
- R8: A `start` raised while a walk is in progress is ignored. The running operation completes with its own operands and gives exactly one `done`.
- R9: After reset, `done` is 0, `sel_count` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| src_vec | input | NUM_ELEM*ELEM_W | Source elements |
| sel_mask | input | NUM_ELEM | Selection bit per source element |
| vl | input | $clog2(NUM_ELEM+1) | Active length |
| old_dest | input | NUM_ELEM*ELEM_W | Previous destination contents, used for kept tail positions |
| tail_fill | input | 1 | Tail policy: 0 keeps old contents, 1 fills with ones |
| result | output | NUM_ELEM*ELEM_W | Packed result |
| sel_count | output | $clog2(NUM_ELEM+1) | Number of kept elements |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker assumes that `sel_mask`, `vl` and `tail_fill` need only be valid in the cycle that `start` is accepted, because it captures its own copy at that edge. It does not assume they stay steady during the walk. The stimulus relies on this: it changes operands and raises `start` in the middle of a walk to show that neither reaches the running operation. The stimulus also drives `vl` values above the element count, which the checker clamps in the same way before it predicts the count and the timing. The stimulus changes inputs only on the falling clock edge, so every value is settled before the accepting edge.

// File: rtl/vcomp_pkg.sv
package vcomp_pkg;

    typedef enum logic {
        TAIL_KEEP = 1'b0,
        TAIL_FILL = 1'b1
    } tail_mode_e;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;

    // One step of the walk as seen by the packing stage
    typedef struct packed {
        logic valid;
        logic take;
        logic last;
    } step_info_t;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vcomp_ctrl.sv
module vcomp_ctrl
    import vcomp_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 8,
    parameter int unsigned CNT_W    = 4,
    parameter int unsigned IDX_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] vl_in,
    output logic [CNT_W-1:0] vl_eff,
    output logic             load,
    output logic             load_final,
    output logic             step,
    output logic             last,
    output logic [IDX_W-1:0] rd_idx,
    output logic             busy,
    output logic             done
);

    walk_state_e      st_q;
    logic [CNT_W-1:0] vl_q;
    logic [IDX_W-1:0] rd_q;
    logic             done_q;

    // clamp the requested length to the element count
    assign vl_eff     = (vl_in > CNT_W'(NUM_ELEM)) ? CNT_W'(NUM_ELEM) : vl_in;
    assign load       = (st_q == WALK_IDLE) && start;
    assign load_final = load && (vl_eff == '0);
    assign step       = (st_q == WALK_RUN);
    assign last       = step && (CNT_W'(rd_q) == (vl_q - CNT_W'(1)));
    assign rd_idx     = rd_q;
    assign busy       = step;
    assign done       = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WALK_IDLE;
            vl_q   <= '0;
            rd_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                WALK_IDLE: begin
                    if (start) begin
                        vl_q <= vl_eff;
                        rd_q <= '0;
                        if (vl_eff == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            st_q <= WALK_RUN;
                        end
                    end
                end
                WALK_RUN: begin
                    rd_q <= rd_q + IDX_W'(1);
                    if (last) begin
                        st_q   <= WALK_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= WALK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vcomp_pick.sv
module vcomp_pick
    import vcomp_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 8,
    parameter int unsigned ELEM_W   = 8,
    parameter int unsigned IDX_W    = 3,
    localparam int unsigned VEC_W   = NUM_ELEM * ELEM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [VEC_W-1:0]  src_in,
    input  logic [NUM_ELEM-1:0] mask_in,
    input  logic              step,
    input  logic              last,
    input  logic [IDX_W-1:0]  rd_idx,
    output step_info_t        info,
    output logic [ELEM_W-1:0] elem
);

    logic [VEC_W-1:0]    src_q;
    logic [NUM_ELEM-1:0] mask_q;
    logic [ELEM_W-1:0]   src_arr [NUM_ELEM];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            mask_q <= '0;
        end else if (load) begin
            src_q  <= src_in;
            mask_q <= mask_in;
        end
    end

    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_split
        assign src_arr[g] = src_q[g*ELEM_W +: ELEM_W];
    end

    assign elem       = src_arr[rd_idx];
    assign info.valid = step;
    assign info.take  = step && mask_q[rd_idx];
    assign info.last  = last;

endmodule

// File: rtl/vcomp_pack.sv
module vcomp_pack
    import vcomp_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 8,
    parameter int unsigned ELEM_W   = 8,
    parameter int unsigned CNT_W    = 4,
    localparam int unsigned VEC_W   = NUM_ELEM * ELEM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              load_final,
    input  logic [VEC_W-1:0]  old_in,
    input  logic              pol_in,
    input  step_info_t        info,
    input  logic [ELEM_W-1:0] elem,
    output logic [VEC_W-1:0]  result,
    output logic [CNT_W-1:0]  count
);

    logic [ELEM_W-1:0] res_q [NUM_ELEM];
    logic [ELEM_W-1:0] res_n [NUM_ELEM];
    logic [CNT_W-1:0]  cnt_q, cnt_n, tail_cnt;
    tail_mode_e        pol_q, tail_mode;
    logic              tail_en;

    always_comb begin
        res_n     = res_q;
        cnt_n     = cnt_q;
        tail_en   = 1'b0;
        tail_mode = pol_q;
        tail_cnt  = cnt_q;
        if (load) begin
            for (int i = 0; i < NUM_ELEM; i++) begin
                res_n[i] = old_in[i*ELEM_W +: ELEM_W];
            end
            cnt_n = '0;
            if (load_final) begin
                tail_en   = 1'b1;
                tail_mode = tail_mode_e'(pol_in);
                tail_cnt  = '0;
            end
        end else if (info.valid) begin
            for (int i = 0; i < NUM_ELEM; i++) begin
                if (info.take && (CNT_W'(i) == cnt_q)) begin
                    res_n[i] = elem;
                end
            end
            cnt_n = cnt_q + CNT_W'(info.take);
            if (info.last) begin
                tail_en  = 1'b1;
                tail_cnt = cnt_n;
            end
        end
        // the tail starts at the kept count, not at the active length
        if (tail_en && (tail_mode == TAIL_FILL)) begin
            for (int i = 0; i < NUM_ELEM; i++) begin
                if (CNT_W'(i) >= tail_cnt) begin
                    res_n[i] = '1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ELEM; i++) begin
                res_q[i] <= '0;
            end
            cnt_q <= '0;
            pol_q <= TAIL_KEEP;
        end else begin
            res_q <= res_n;
            cnt_q <= cnt_n;
            if (load) begin
                pol_q <= tail_mode_e'(pol_in);
            end
        end
    end

    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_join
        assign result[g*ELEM_W +: ELEM_W] = res_q[g];
    end

    assign count = cnt_q;

endmodule

// File: rtl/vcomp_unit.sv
module vcomp_unit
    import vcomp_pkg::*;
#(
    parameter int unsigned NUM_ELEM = 8,
    parameter int unsigned ELEM_W   = 8,
    localparam int unsigned CNT_W   = $clog2(NUM_ELEM + 1),
    localparam int unsigned IDX_W   = idx_bits(NUM_ELEM),
    localparam int unsigned VEC_W   = NUM_ELEM * ELEM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [VEC_W-1:0]    src_vec,
    input  logic [NUM_ELEM-1:0] sel_mask,
    input  logic [CNT_W-1:0]    vl,
    input  logic [VEC_W-1:0]    old_dest,
    input  logic                tail_fill,
    output logic [VEC_W-1:0]    result,
    output logic [CNT_W-1:0]    sel_count,
    output logic                done
);

    logic [CNT_W-1:0]  vl_eff_w;
    logic              load_w, load_final_w, step_w, last_w, busy_w;
    logic [IDX_W-1:0]  rd_idx_w;
    step_info_t        info_w;
    logic [ELEM_W-1:0] elem_w;

    vcomp_ctrl #(
        .NUM_ELEM(NUM_ELEM), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) ctrl_i (
        .clk(clk), .rst(rst), .start(start), .vl_in(vl),
        .vl_eff(vl_eff_w), .load(load_w), .load_final(load_final_w),
        .step(step_w), .last(last_w), .rd_idx(rd_idx_w),
        .busy(busy_w), .done(done)
    );

    vcomp_pick #(
        .NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .IDX_W(IDX_W)
    ) pick_i (
        .clk(clk), .rst(rst), .load(load_w), .src_in(src_vec),
        .mask_in(sel_mask), .step(step_w), .last(last_w),
        .rd_idx(rd_idx_w), .info(info_w), .elem(elem_w)
    );

    vcomp_pack #(
        .NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .CNT_W(CNT_W)
    ) pack_i (
        .clk(clk), .rst(rst), .load(load_w), .load_final(load_final_w),
        .old_in(old_dest), .pol_in(tail_fill), .info(info_w),
        .elem(elem_w), .result(result), .count(sel_count)
    );

endmodule

// File: rtl/vcomp_unit_chk.sv
module vcomp_unit_chk #(
    parameter int unsigned NUM_ELEM = 8,
    parameter int unsigned ELEM_W   = 8,
    localparam int unsigned CNT_W   = $clog2(NUM_ELEM + 1),
    localparam int unsigned VEC_W   = NUM_ELEM * ELEM_W
) (
    input logic                clk,
    input logic                rst,
    input logic                load,
    input logic [CNT_W-1:0]    vl_eff,
    input logic [NUM_ELEM-1:0] mask_in,
    input logic                pol_in,
    input logic                busy,
    input logic                done,
    input logic [CNT_W-1:0]    sel_count,
    input logic [VEC_W-1:0]    result
);

    logic [CNT_W-1:0]    vl_lat, exp_cnt, left_q;
    logic                pol_lat;
    logic [NUM_ELEM-1:0] low;
    logic                tail_ok;

    always_comb begin
        for (int i = 0; i < NUM_ELEM; i++) begin
            low[i] = (i < int'(vl_eff));
        end
    end

    always_comb begin
        tail_ok = 1'b1;
        for (int i = 0; i < NUM_ELEM; i++) begin
            if (pol_lat && (i >= int'(sel_count)) &&
                (result[i*ELEM_W +: ELEM_W] != {ELEM_W{1'b1}})) begin
                tail_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_lat  <= '0;
            exp_cnt <= '0;
            left_q  <= '0;
            pol_lat <= 1'b0;
        end else if (load) begin
            vl_lat  <= vl_eff;
            exp_cnt <= CNT_W'($countones(mask_in & low));
            left_q  <= vl_eff;
            pol_lat <= pol_in;
        end else if (left_q != '0) begin
            left_q <= left_q - CNT_W'(1);
        end
    end

    // R3
    count_match_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (sel_count == exp_cnt));

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (sel_count <= vl_lat));

    // R5
    tail_ones_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> tail_ok);

    // R6
    done_on_time_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (left_q == CNT_W'(1))) |=> done);

    // R6
    no_early_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (left_q > CNT_W'(1))) |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind vcomp_unit vcomp_unit_chk #(
    .NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)
) chk_i (
    .clk(clk), .rst(rst), .load(load_w), .vl_eff(vl_eff_w),
    .mask_in(sel_mask), .pol_in(tail_fill), .busy(busy_w),
    .done(done), .sel_count(sel_count), .result(result)
);

// File: tb/vcomp_unit_test.sv
`timescale 1ns/1ps
module vcomp_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] src_vec = '0;
    logic [7:0]  sel_mask = '0;
    logic [3:0]  vl = '0;
    logic [63:0] old_dest = '0;
    logic        tail_fill = 1'b0;
    logic [63:0] result;
    logic [3:0]  sel_count;
    logic        done;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    vcomp_unit #(.NUM_ELEM(8), .ELEM_W(8)) uut (
        .clk(clk), .rst(rst), .start(start), .src_vec(src_vec),
        .sel_mask(sel_mask), .vl(vl), .old_dest(old_dest),
        .tail_fill(tail_fill), .result(result), .sel_count(sel_count),
        .done(done)
    );

    typedef struct packed {
        logic [63:0] src;
        logic [7:0]  mask;
        logic [3:0]  len;
        logic [63:0] old;
        logic        pol;
        logic [63:0] exp_res;
        logic [3:0]  exp_cnt;
    } vec_t;

    localparam logic [63:0] SRC = 64'hA7A6A5A4A3A2A1A0;
    localparam logic [63:0] OLD = 64'h1716151413121110;

    localparam vec_t TABLE [8] = '{
        '{SRC, 8'b1010_0101, 4'd8,  OLD, 1'b0, 64'h17161514A7A5A2A0, 4'd4},
        '{SRC, 8'b1010_0101, 4'd8,  OLD, 1'b1, 64'hFFFFFFFFA7A5A2A0, 4'd4},
        '{SRC, 8'b1111_1111, 4'd5,  OLD, 1'b0, 64'h171615A4A3A2A1A0, 4'd5},
        '{SRC, 8'b1111_0000, 4'd4,  OLD, 1'b0, OLD,                  4'd0},
        '{SRC, 8'b1100_0001, 4'd7,  OLD, 1'b1, 64'hFFFFFFFFFFFFA6A0, 4'd2},
        '{SRC, 8'b0000_0000, 4'd8,  OLD, 1'b1, 64'hFFFFFFFFFFFFFFFF, 4'd0},
        '{SRC, 8'b1000_0000, 4'd8,  OLD, 1'b0, 64'h17161514131211A7, 4'd1},
        '{SRC, 8'b1111_1111, 4'd12, OLD, 1'b0, SRC,                  4'd8}
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] s, input logic [7:0] m,
                          input logic [3:0] l, input logic [63:0] o,
                          input logic p, output int lat);
        @(negedge clk);
        src_vec = s; sel_mask = m; vl = l; old_dest = o; tail_fill = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check("R9", "done after reset", 64'(done), 64'd0);
        check("R9", "count after reset", 64'(sel_count), 64'd0);
        check("R9", "result after reset", result, 64'd0);

        // table walk: R1 R2 R3 R4 R5 R6 R7
        for (int k = 0; k < 8; k++) begin
            int exp_lat;
            run_op(TABLE[k].src, TABLE[k].mask, TABLE[k].len, TABLE[k].old,
                   TABLE[k].pol, lat);
            exp_lat = (TABLE[k].len > 4'd8) ? 8 : int'(TABLE[k].len);
            check("R1/R4/R5", $sformatf("result vec %0d", k), result, TABLE[k].exp_res);
            check("R2/R3", $sformatf("count vec %0d", k), 64'(sel_count), 64'(TABLE[k].exp_cnt));
            check("R6/R7", $sformatf("latency vec %0d", k), 64'(lat), 64'(exp_lat));
            @(negedge clk);
            check("R6", $sformatf("done drop vec %0d", k), 64'(done), 64'd0);
        end

        // R6 R5: zero length with fill policy
        run_op(SRC, 8'hFF, 4'd0, OLD, 1'b1, lat);
        check("R6", "latency vl=0", 64'(lat), 64'd0);
        check("R5", "result vl=0 fill", result, 64'hFFFFFFFFFFFFFFFF);
        check("R3", "count vl=0", 64'(sel_count), 64'd0);
        @(negedge clk);
        check("R6", "done drop vl=0", 64'(done), 64'd0);

        // R4: zero length with keep policy
        run_op(SRC, 8'hFF, 4'd0, OLD, 1'b0, lat);
        check("R4", "result vl=0 keep", result, OLD);

        // R8: start during a walk is ignored
        @(negedge clk);
        src_vec = SRC; sel_mask = 8'b1010_0101; vl = 4'd8; old_dest = OLD;
        tail_fill = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        src_vec = 64'h0; sel_mask = 8'hFF; vl = 4'd2; old_dest = 64'h0;
        tail_fill = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check("R8", "latency with stray start", 64'(lat), 64'd8);
        check("R8", "result with stray start", result, 64'h17161514A7A5A2A0);
        check("R8", "count with stray start", 64'(sel_count), 64'd4);
        begin
            int extra = 0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check("R8", "single done pulse", 64'(extra), 64'd0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule